// File: doc/BRIEF.md
# LCD Scanline and Display-Mode Sequencer

This block produces the raster timing of a small handheld-style LCD controller with a 160x144 visible area. A dot counter walks each scanline and a line counter walks each frame. From the position it derives the 2-bit display mode: OAM scan, then draw, then horizontal blank on visible lines, and vertical blank on the lines below the screen. It also keeps a line-compare flag and emits one-cycle interrupt request strobes for vertical blank and for status events. The strobes are meant to feed an interrupt-flag register elsewhere.

Software reaches the block through a write strobe on the LCD control register. The compare line value and the status fields are plain inputs and outputs, so the surrounding register file can place them at its own addresses. Bit 7 of the control register turns the display on. While that bit is clear, the counters and the mode freeze and no request is raised. Writing the register with bit 7 set restarts the raster at line 0, dot 0.

Top module: `lcd_timing_seq`

## Requirements
- R1: After reset, ctrl_q, ly, dot, stat_mode, stat_coinc, irq_vblank and irq_stat are all 0.
- R2: While ctrl_q[7] is 1 and no write is presented, dot steps by one every clock from 0 up to DOTS_PER_LINE-1 and then returns to 0. At that return, ly advances by one.
- R3: ly counts 0 to TOTAL_LINES-1. After the last dot of line TOTAL_LINES-1, ly and dot both return to 0.
- R4: stat_mode uses the encoding 0 = horizontal blank, 1 = vertical blank, 2 = OAM scan, 3 = draw. On a line with ly < VIS_LINES, the mode is 2 for dot < DRAW_START, 3 for DRAW_START <= dot < HBLANK_START, and 0 from HBLANK_START on.
- R5: On lines with ly >= VIS_LINES, stat_mode is 1. irq_vblank is high for exactly the one cycle in which the position is ly = VIS_LINES, dot = 0, and at no other time.
- R6: irq_stat is high for one cycle when the position enters dot 0 of a visible line, and when it enters dot HBLANK_START of a visible line.
- R7: Each time the raster enters a new line, stat_coinc is loaded with (new ly == lyc). If they are equal, irq_stat is also raised in that cycle. Between line entries, stat_coinc holds its value even if lyc changes.
- R8: While ctrl_q[7] is 0, ly, dot, stat_mode and stat_coinc hold their values and neither request is raised.
- R9: A write (ctrl_wr) stores ctrl_wdata into ctrl_q on the next clock. The write takes priority over that clock's raster step. If ctrl_wdata[7] is 1, the next cycle shows ly = 0, dot = 0, stat_mode = 2 and stat_coinc = (lyc == 0), with no request raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data; bit 7 enables the display |
| lyc | input | 8 | Line-compare value |
| ctrl_q | output | 8 | Current control register contents |
| ly | output | 8 | Current line number |
| dot | output | $clog2(DOTS_PER_LINE) | Current dot within the line |
| stat_mode | output | 2 | Display mode field of the status register |
| stat_coinc | output | 1 | Line-compare flag of the status register |
| irq_vblank | output | 1 | One-cycle vertical blank request |
| irq_stat | output | 1 | One-cycle status request |

## Verification
The bench builds the sequencer with 20 dots per line, 4 visible lines, 6 lines per frame, draw starting at dot 5 and horizontal blank at dot 12. A whole frame then takes only 120 clocks, so every dot of every line can be compared against a position computed arithmetically from the cycle count since the last restart. The run covers two full frames for each of several compare values, including one that never matches, so the frame wrap, the vertical blank entry and every mode boundary are each crossed more than once. With frames this short, the bench can also afford to change the compare value mid-line, disable the display mid-frame, and restart the raster on the very last dot before vertical blank.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    LM_HBLANK = 2'd0,
    LM_VBLANK = 2'd1,
    LM_OAM    = 2'd2,
    LM_DRAW   = 2'd3
  } lcd_mode_e;

  localparam int CTRL_W      = 8;
  localparam int CTRL_EN_BIT = 7;
  localparam int LY_W        = 8;

endpackage

// File: rtl/lcd_pos_counter.sv
module lcd_pos_counter #(
  parameter int DOTS_PER_LINE = 456,
  parameter int TOTAL_LINES   = 154,
  parameter int DOT_W         = $clog2(DOTS_PER_LINE),
  parameter int LY_W          = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            restart,
  output logic [DOT_W-1:0] dot_q,
  output logic [LY_W-1:0]  ly_q,
  output logic [DOT_W-1:0] dot_nxt,
  output logic [LY_W-1:0]  ly_nxt,
  output logic            line_adv
);

  localparam logic [DOT_W-1:0] DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [LY_W-1:0]  LINE_LAST = LY_W'(TOTAL_LINES - 1);

  logic pos_en;

  // next-state
  always_comb begin
    dot_nxt  = dot_q;
    ly_nxt   = ly_q;
    line_adv = 1'b0;
    if (restart) begin
      dot_nxt = '0;
      ly_nxt  = '0;
    end else if (step) begin
      if (dot_q == DOT_LAST) begin
        dot_nxt  = '0;
        line_adv = 1'b1;
        if (ly_q == LINE_LAST) begin
          ly_nxt = '0;
        end else begin
          ly_nxt = ly_q + 1'b1;
        end
      end else begin
        dot_nxt = dot_q + 1'b1;
      end
    end
  end

  assign pos_en = restart | step;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q <= '0;
      ly_q  <= '0;
    end else if (pos_en) begin
      dot_q <= dot_nxt;
      ly_q  <= ly_nxt;
    end
  end

endmodule

// File: rtl/lcd_mode_decode.sv
module lcd_mode_decode
  import lcd_seq_pkg::*;
#(
  parameter int DOTS_PER_LINE = 456,
  parameter int VIS_LINES     = 144,
  parameter int DRAW_START    = 81,
  parameter int HBLANK_START  = 253,
  parameter int DOT_W         = $clog2(DOTS_PER_LINE),
  parameter int LY_W          = 8
) (
  input  logic [DOT_W-1:0] dot,
  input  logic [LY_W-1:0]  ly,
  output lcd_mode_e        mode,
  output logic             oam_entry,
  output logic             hblank_entry,
  output logic             vblank_entry
);

  localparam logic [DOT_W-1:0] DOT_DRAW = DOT_W'(DRAW_START);
  localparam logic [DOT_W-1:0] DOT_HBL  = DOT_W'(HBLANK_START);
  localparam logic [LY_W-1:0]  LY_VBL   = LY_W'(VIS_LINES);

  logic visible;
  logic at_line_start;

  assign visible       = (ly < LY_VBL);
  assign at_line_start = (dot == '0);

  always_comb begin
    if (!visible) begin
      mode = LM_VBLANK;
    end else if (dot < DOT_DRAW) begin
      mode = LM_OAM;
    end else if (dot < DOT_HBL) begin
      mode = LM_DRAW;
    end else begin
      mode = LM_HBLANK;
    end
  end

  assign oam_entry    = visible & at_line_start;
  assign hblank_entry = visible & (dot == DOT_HBL);
  assign vblank_entry = (ly == LY_VBL) & at_line_start;

endmodule

// File: rtl/lcd_event_gen.sv
module lcd_event_gen
  import lcd_seq_pkg::*;
#(
  parameter int LY_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            restart,
  input  logic            line_adv,
  input  lcd_mode_e       mode_nxt,
  input  logic            oam_entry,
  input  logic            hblank_entry,
  input  logic            vblank_entry,
  input  logic [LY_W-1:0] ly_nxt,
  input  logic [LY_W-1:0] lyc,
  output lcd_mode_e       mode_q,
  output logic            coinc_q,
  output logic            irq_stat_q,
  output logic            irq_vblank_q
);

  logic ly_hit;
  logic mode_en;
  logic coinc_en;
  logic irq_stat_d;
  logic irq_vblank_d;

  // next-state
  always_comb begin
    ly_hit       = (ly_nxt == lyc);
    mode_en      = restart | step;
    coinc_en     = restart | line_adv;
    irq_stat_d   = step & (oam_entry | hblank_entry | (line_adv & ly_hit));
    irq_vblank_d = step & vblank_entry;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LM_HBLANK;
    end else if (mode_en) begin
      mode_q <= mode_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coinc_q <= 1'b0;
    end else if (coinc_en) begin
      coinc_q <= ly_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_stat_q   <= 1'b0;
      irq_vblank_q <= 1'b0;
    end else begin
      irq_stat_q   <= irq_stat_d;
      irq_vblank_q <= irq_vblank_d;
    end
  end

endmodule

// File: rtl/lcd_timing_seq.sv
module lcd_timing_seq
  import lcd_seq_pkg::*;
#(
  parameter int DOTS_PER_LINE = 456,
  parameter int VIS_LINES     = 144,
  parameter int TOTAL_LINES   = 154,
  parameter int DRAW_START    = 81,
  parameter int HBLANK_START  = 253
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ctrl_wr,
  input  logic [7:0]                       ctrl_wdata,
  input  logic [7:0]                       lyc,
  output logic [7:0]                       ctrl_q,
  output logic [7:0]                       ly,
  output logic [$clog2(DOTS_PER_LINE)-1:0] dot,
  output logic [1:0]                       stat_mode,
  output logic                             stat_coinc,
  output logic                             irq_vblank,
  output logic                             irq_stat
);

  localparam int DOT_W = $clog2(DOTS_PER_LINE);
  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // control register
  logic [CTRL_W-1:0] ctrl_d;
  logic              lcd_on;
  logic              step;
  logic              restart;

  always_comb begin
    ctrl_d  = ctrl_wr ? ctrl_wdata : ctrl_q;
    lcd_on  = ctrl_q[CTRL_EN_BIT];
    step    = lcd_on & ~ctrl_wr;
    restart = ctrl_wr & ctrl_wdata[CTRL_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  // raster position
  logic [DOT_W-1:0] dot_nxt;
  logic [LY_W-1:0]  ly_nxt;
  logic             line_adv;

  lcd_pos_counter #(
    .DOTS_PER_LINE (DOTS_PER_LINE),
    .TOTAL_LINES   (TOTAL_LINES),
    .DOT_W         (DOT_W),
    .LY_W          (LY_W)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (step),
    .restart  (restart),
    .dot_q    (dot),
    .ly_q     (ly),
    .dot_nxt  (dot_nxt),
    .ly_nxt   (ly_nxt),
    .line_adv (line_adv)
  );

  // mode of the position about to be entered
  lcd_mode_e mode_nxt;
  lcd_mode_e mode_q;
  logic      oam_entry;
  logic      hblank_entry;
  logic      vblank_entry;

  lcd_mode_decode #(
    .DOTS_PER_LINE (DOTS_PER_LINE),
    .VIS_LINES     (VIS_LINES),
    .DRAW_START    (DRAW_START),
    .HBLANK_START  (HBLANK_START),
    .DOT_W         (DOT_W),
    .LY_W          (LY_W)
  ) u_dec (
    .dot          (dot_nxt),
    .ly           (ly_nxt),
    .mode         (mode_nxt),
    .oam_entry    (oam_entry),
    .hblank_entry (hblank_entry),
    .vblank_entry (vblank_entry)
  );

  lcd_event_gen #(
    .LY_W (LY_W)
  ) u_evt (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .step         (step),
    .restart      (restart),
    .line_adv     (line_adv),
    .mode_nxt     (mode_nxt),
    .oam_entry    (oam_entry),
    .hblank_entry (hblank_entry),
    .vblank_entry (vblank_entry),
    .ly_nxt       (ly_nxt),
    .lyc          (lyc),
    .mode_q       (mode_q),
    .coinc_q      (stat_coinc),
    .irq_stat_q   (irq_stat),
    .irq_vblank_q (irq_vblank)
  );

  assign stat_mode = mode_q;

endmodule

// File: rtl/lcd_timing_seq_chk.sv
module lcd_timing_seq_chk #(
  parameter int DOTS_PER_LINE = 456,
  parameter int VIS_LINES     = 144,
  parameter int TOTAL_LINES   = 154,
  parameter int DRAW_START    = 81,
  parameter int HBLANK_START  = 253
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             ctrl_wr,
  input logic [7:0]                       ctrl_wdata,
  input logic [7:0]                       ctrl_q,
  input logic [7:0]                       ly,
  input logic [$clog2(DOTS_PER_LINE)-1:0] dot,
  input logic [1:0]                       stat_mode,
  input logic                             stat_coinc,
  input logic                             irq_vblank,
  input logic                             irq_stat
);

  localparam int DOT_W = $clog2(DOTS_PER_LINE);
  localparam logic [DOT_W-1:0] C_DLAST = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0] C_DRAW  = DOT_W'(DRAW_START);
  localparam logic [DOT_W-1:0] C_HBL   = DOT_W'(HBLANK_START);
  localparam logic [7:0]       C_VIS   = 8'(VIS_LINES);
  localparam logic [7:0]       C_LLAST = 8'(TOTAL_LINES - 1);

  logic running;
  assign running = ctrl_q[7] & ~ctrl_wr;

  // R2: dot steps inside a line
  a_r2_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && dot != C_DLAST) |=> (dot == $past(dot) + 1'b1) && (ly == $past(ly)));

  // R2/R3: end of line advances or wraps the line counter
  a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running && dot == C_DLAST) |=>
      (dot == '0) && (ly == (($past(ly) == C_LLAST) ? 8'd0 : $past(ly) + 8'd1)));

  // R4: draw and horizontal blank regions of visible lines
  a_r4_draw_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ly < C_VIS && dot >= C_DRAW && dot < C_HBL) |-> stat_mode == 2'd3);

  a_r4_hblank_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ly < C_VIS && dot >= C_HBL) |-> stat_mode == 2'd0);

  // R5: vertical blank mode and pulse position
  a_r5_vblank_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ly >= C_VIS) |-> stat_mode == 2'd1);

  a_r5_vblank_where: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vblank |-> (ly == C_VIS && dot == '0));

  a_r5_vblank_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vblank |=> !irq_vblank);

  // R6/R7: status request only at a line entry or horizontal blank entry
  a_r6_stat_where: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat |-> (dot == '0 || (dot == C_HBL && ly < C_VIS)));

  // R7: compare flag changes only at dot 0
  a_r7_coinc_line: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_coinc) |-> dot == '0);

  // R8: frozen while disabled
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[7] && !ctrl_wr) |=>
      $stable(ly) && $stable(dot) && $stable(stat_mode) && $stable(stat_coinc)
      && !irq_stat && !irq_vblank);

  // R9: enabling write restarts the raster
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[7]) |=>
      (ly == 8'd0) && (dot == '0) && (stat_mode == 2'd2) && !irq_stat && !irq_vblank
      && (ctrl_q == $past(ctrl_wdata)));

endmodule

bind lcd_timing_seq lcd_timing_seq_chk #(
  .DOTS_PER_LINE (DOTS_PER_LINE),
  .VIS_LINES     (VIS_LINES),
  .TOTAL_LINES   (TOTAL_LINES),
  .DRAW_START    (DRAW_START),
  .HBLANK_START  (HBLANK_START)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_wr    (ctrl_wr),
  .ctrl_wdata (ctrl_wdata),
  .ctrl_q     (ctrl_q),
  .ly         (ly),
  .dot        (dot),
  .stat_mode  (stat_mode),
  .stat_coinc (stat_coinc),
  .irq_vblank (irq_vblank),
  .irq_stat   (irq_stat)
);

// File: tb/lcd_timing_seq_test.sv
`timescale 1ns/1ps
module lcd_timing_seq_test;

  localparam int DOTS  = 20;
  localparam int VIS   = 4;
  localparam int TOTAL = 6;
  localparam int DRAW  = 5;
  localparam int HBL   = 12;
  localparam int FRAME = DOTS * TOTAL;
  localparam int DW    = $clog2(DOTS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctrl_wr;
  logic [7:0]    ctrl_wdata;
  logic [7:0]    lyc;
  logic [7:0]    ctrl_q;
  logic [7:0]    ly;
  logic [DW-1:0] dot;
  logic [1:0]    stat_mode;
  logic          stat_coinc;
  logic          irq_vblank;
  logic          irq_stat;

  always #4 clk = ~clk;

  lcd_timing_seq #(
    .DOTS_PER_LINE (DOTS),
    .VIS_LINES     (VIS),
    .TOTAL_LINES   (TOTAL),
    .DRAW_START    (DRAW),
    .HBLANK_START  (HBL)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .lyc        (lyc),
    .ctrl_q     (ctrl_q),
    .ly         (ly),
    .dot        (dot),
    .stat_mode  (stat_mode),
    .stat_coinc (stat_coinc),
    .irq_vblank (irq_vblank),
    .irq_stat   (irq_stat)
  );

  int  n_cmp  = 0;
  int  n_bad  = 0;
  bit  done   = 0;
  int  k      = 0;
  bit  coinc_e;

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", what, act, exp, k);
    end
  endtask

  function automatic int exp_mode(input int ln, input int d);
    if (ln >= VIS) return 1;
    if (d < DRAW)  return 2;
    if (d < HBL)   return 3;
    return 0;
  endfunction

  // compare all outputs with the position k cycles after the last restart
  task automatic check_pos(input string tag, input bit frozen);
    int p  = k % FRAME;
    int ln = p / DOTS;
    int d  = p % DOTS;
    bit st = !frozen && k > 0 && ((ln < VIS && (d == 0 || d == HBL)) ||
                                  (d == 0 && ln == int'(lyc)));
    bit vb = !frozen && k > 0 && ln == VIS && d == 0;
    chk({tag, " R2 dot"}, int'(dot), d);
    chk({tag, " R3 ly"}, int'(ly), ln);
    chk({tag, " R4 mode"}, int'(stat_mode), exp_mode(ln, d));
    chk({tag, " R5 vblank"}, int'(irq_vblank), int'(vb));
    chk({tag, " R6 stat"}, int'(irq_stat), int'(st));
    chk({tag, " R7 coinc"}, int'(stat_coinc), int'(coinc_e));
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    ctrl_wr    = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr    = 1'b0;
    chk("R9 ctrl_q", int'(ctrl_q), int'(v));
  endtask

  task automatic enable(input logic [7:0] v);
    write_ctrl(v);
    k       = 0;
    coinc_e = (lyc == 8'd0);
    check_pos("R9 restart", 1'b0);
  endtask

  task automatic advance(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      k++;
      if ((k % FRAME) % DOTS == 0) coinc_e = (int'(lyc) == (k % FRAME) / DOTS);
      check_pos("run", 1'b0);
    end
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_pos("R8 hold", 1'b1);
    end
  endtask

  initial begin
    int lyc_set [4] = '{0, 2, 5, 9};
    rst_n      = 1'b0;
    ctrl_wr    = 1'b0;
    ctrl_wdata = 8'h00;
    lyc        = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ctrl_q", int'(ctrl_q), 0);
    chk("R1 ly", int'(ly), 0);
    chk("R1 dot", int'(dot), 0);
    chk("R1 mode", int'(stat_mode), 0);
    chk("R1 coinc", int'(stat_coinc), 0);
    chk("R1 vblank", int'(irq_vblank), 0);
    chk("R1 stat", int'(irq_stat), 0);

    // R8 idle after reset: nothing moves
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R8 idle dot", int'(dot), 0);
      chk("R8 idle ly", int'(ly), 0);
      chk("R8 idle mode", int'(stat_mode), 0);
      chk("R8 idle irq", int'(irq_stat | irq_vblank), 0);
    end

    // full-frame sweeps for several compare values
    for (int i = 0; i < 4; i++) begin
      lyc = 8'(lyc_set[i]);
      enable(8'h80);
      advance(2 * FRAME);
    end

    // R7: compare value changes between line entries
    lyc = 8'd3;
    enable(8'h91);
    advance(5);
    lyc = 8'd0;
    advance(30);
    lyc = 8'd2;
    advance(DOTS);

    // R9: restart mid-line
    enable(8'h80);
    advance(17);

    // R8: disable mid-frame, rewrite while off, lyc change has no effect
    write_ctrl(8'h05);
    check_pos("R8 off", 1'b1);
    hold(15);
    lyc = 8'(((k % FRAME) / DOTS + 1) % TOTAL);
    write_ctrl(8'h00);
    check_pos("R8 rewrite", 1'b1);
    hold(8);
    lyc = 8'd1;
    enable(8'h80);
    advance(FRAME);

    // R9: restart on the last dot before vertical blank has priority
    enable(8'h80);
    advance(VIS * DOTS - 1);
    enable(8'hC0);
    advance(DOTS + 3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule